// File: doc/BRIEF.md
# Addressed SPI Control-Port Slave

This block receives register writes from a microcontroller over a three-wire, write-only serial control port (chip select, bit clock, data in). A transaction opens when chip select goes low. The first byte carries a fixed 7-bit device address followed by a direction bit. The second byte is a register pointer. Every byte after that is written into the register file at the pointer, and the pointer advances by one after each byte.

All three serial lines are resynchronised into the system clock and sampled there. Each accepted data byte comes out as a one-cycle write strobe with its address and data. A sticky flag records that the control port is in SPI mode. It is set by the first falling edge of chip select after reset.

Top module: `spiCtrlPort`

## Requirements
- R1: After reset `regWrEn` is 0 and `spiMode` is 0.
- R2: `spiMode` becomes 1 after the first high-to-low transition of `csN` and stays 1 until the next reset.
- R3: Bits are taken MSB first on rising `cclk` edges while `csN` is low. A first byte equal to 8'h20 (device address 7'b0010000 in bits 7:1, direction bit 0 in bit 0) accepts the transaction. The second byte loads the pointer, and each later complete byte writes `regData` at `regAddr` = pointer.
- R4: If bits 7:1 of the first byte differ from 7'b0010000, no write occurs until `csN` returns high.
- R5: If the direction bit (bit 0 of the first byte) is 1, no write occurs in that transaction.
- R6: Consecutive data bytes in one transaction go to consecutive addresses, and the pointer wraps from 8'hFF to 8'h00.
- R7: When `csN` rises in the middle of a byte, that byte is dropped without a write. The next transaction starts again from bit 0 of a new first byte.
- R8: A transaction that ends before any data byte is complete (after the first byte or during the pointer byte) writes nothing.
- R9: `regWrEn` is high for exactly one system-clock cycle per accepted data byte.
- R10: `cclk` edges while `csN` is high have no effect on later transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock |
| sysRstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| cclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| cdin | input | 1 | Serial data in, MSB first |
| regWrEn | output | 1 | One-cycle register write strobe |
| regAddr | output | PTR_W | Register address of the write |
| regData | output | 8 | Register data of the write |
| spiMode | output | 1 | Sticky SPI-mode flag |

## Verification
The bench sweeps all 256 values of the first byte, each with its own pointer and data. Exactly one value must produce a write. A decoder that ignored the direction bit or compared the wrong bits would write on two codes or on none. Burst writes that cross 8'hFF show whether the pointer wraps: a design that failed to increment would overwrite one register, and one that saturated would repeat 8'hFF. Aborts mid-byte, after the address and during the pointer byte catch a bit counter that is not cleared. Such a design would emit a stray write or shift the next transaction's bytes. The bench also toggles `cclk` while `csN` is high, which catches a design that samples the clock without qualifying it by chip select.

// File: rtl/spiPkg.sv
package spiPkg;
  typedef struct packed {
    logic shiftEn;
    logic loadPtr;
    logic writeByte;
    logic setMode;
  } dpStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_SKIP
  } portStateT;
endpackage

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic     sysClk,
  input  logic     sysRstN,
  input  logic     csN,
  input  logic     cclk,
  input  logic     cdin,
  input  logic     addrOk,
  output logic     dinBit,
  output logic     csActive,
  output dpStrobeT strobes
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, dinPipe;
  logic csPrev, clkPrev;
  logic csLow, csFall, clkRise, lastBit, bitTake;
  logic [CNT_W-1:0] bitCnt;
  portStateT state;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      dinPipe <= '0;
      csPrev  <= 1'b1;
      clkPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], cclk};
      dinPipe <= {dinPipe[SYNC_STAGES-2:0], cdin};
      csPrev  <= csPipe[SYNC_STAGES-1];
      clkPrev <= clkPipe[SYNC_STAGES-1];
    end
  end

  always_comb begin
    csLow   = !csPipe[SYNC_STAGES-1];
    csFall  = csPrev && csLow;
    clkRise = clkPipe[SYNC_STAGES-1] && !clkPrev;
    lastBit = (bitCnt == LAST_BIT);
    bitTake = clkRise && csLow &&
              (state == ST_ADDR || state == ST_PTR || state == ST_DATA);
    dinBit   = dinPipe[SYNC_STAGES-1];
    csActive = csLow;
    strobes.setMode   = csFall;
    strobes.shiftEn   = bitTake;
    strobes.loadPtr   = bitTake && lastBit && (state == ST_PTR);
    strobes.writeByte = bitTake && lastBit && (state == ST_DATA);
  end

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (!csLow) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (state == ST_IDLE) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (bitTake) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) begin
        unique case (state)
          ST_ADDR: state <= addrOk ? ST_PTR : ST_SKIP;
          ST_PTR:  state <= ST_DATA;
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPkg::*;
#(
  parameter int         PTR_W     = 8,
  parameter int         BYTE_W    = 8,
  parameter logic [6:0] CHIP_ADDR = 7'b0010000
) (
  input  logic              sysClk,
  input  logic              sysRstN,
  input  dpStrobeT          strobes,
  input  logic              dinBit,
  output logic              addrOk,
  output logic              regWrEn,
  output logic [PTR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regData,
  output logic              spiMode
);
  localparam logic [BYTE_W-1:0] WRITE_HDR = BYTE_W'({CHIP_ADDR, 1'b0});

  logic [BYTE_W-1:0] shiftReg, nextByte;
  logic [PTR_W-1:0]  ptr;

  always_comb begin
    nextByte = {shiftReg[BYTE_W-2:0], dinBit};
    addrOk   = (nextByte == WRITE_HDR);
  end

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      shiftReg <= '0;
      ptr      <= '0;
      regWrEn  <= 1'b0;
      regAddr  <= '0;
      regData  <= '0;
      spiMode  <= 1'b0;
    end else begin
      regWrEn <= 1'b0;
      if (strobes.setMode) spiMode <= 1'b1;
      if (strobes.shiftEn) shiftReg <= nextByte;
      if (strobes.loadPtr) ptr <= PTR_W'(nextByte);
      if (strobes.writeByte) begin
        regWrEn <= 1'b1;
        regAddr <= ptr;
        regData <= nextByte;
        ptr     <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiCtrlPort.sv
module spiCtrlPort
  import spiPkg::*;
#(
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] CHIP_ADDR   = 7'b0010000
) (
  input  logic             sysClk,
  input  logic             sysRstN,
  input  logic             csN,
  input  logic             cclk,
  input  logic             cdin,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regData,
  output logic             spiMode
);
  dpStrobeT strobes;
  logic addrOk, dinBit, csActive;

  spiCtrl #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(8)) i_ctrl (
    .sysClk(sysClk), .sysRstN(sysRstN), .csN(csN), .cclk(cclk), .cdin(cdin),
    .addrOk(addrOk), .dinBit(dinBit), .csActive(csActive), .strobes(strobes)
  );

  spiDatapath #(.PTR_W(PTR_W), .BYTE_W(8), .CHIP_ADDR(CHIP_ADDR)) i_dp (
    .sysClk(sysClk), .sysRstN(sysRstN), .strobes(strobes), .dinBit(dinBit),
    .addrOk(addrOk), .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .spiMode(spiMode)
  );
endmodule

// File: rtl/spiCtrlPortChk.sv
module spiCtrlPortChk #(
  parameter int PTR_W = 8
) (
  input logic             sysClk,
  input logic             sysRstN,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regAddr,
  input logic             spiMode,
  input logic             csActive
);
  logic             haveLast;
  logic [PTR_W-1:0] lastAddr;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      haveLast <= 1'b0;
      lastAddr <= '0;
    end else if (!csActive) begin
      haveLast <= 1'b0;
    end else if (regWrEn) begin
      haveLast <= 1'b1;
      lastAddr <= regAddr;
    end
  end

  AST_MODE_STICKY: assert property (@(posedge sysClk) disable iff (!sysRstN) spiMode |=> spiMode); // R2
  AST_WR_NEEDS_MODE: assert property (@(posedge sysClk) disable iff (!sysRstN) regWrEn |-> spiMode); // R3
  AST_ADDR_CONSEC: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (regWrEn && haveLast) |-> (regAddr == lastAddr + 1'b1)); // R6
  AST_WR_IN_TXN: assert property (@(posedge sysClk) disable iff (!sysRstN) $rose(regWrEn) |-> $past(csActive)); // R7
  AST_WR_PULSE: assert property (@(posedge sysClk) disable iff (!sysRstN) regWrEn |=> !regWrEn); // R9
endmodule

bind spiCtrlPort spiCtrlPortChk #(.PTR_W(PTR_W)) i_chk (
  .sysClk(sysClk), .sysRstN(sysRstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .spiMode(spiMode), .csActive(csActive)
);

// File: tb/test_spiCtrlPort.sv
`timescale 1ns/1ps
module test_spiCtrlPort;
  logic sysClk = 1'b0, sysRstN = 1'b0;
  logic csN = 1'b1, cclk = 1'b0, cdin = 1'b0;
  logic regWrEn, spiMode;
  logic [7:0] regAddr, regData;

  int nChk = 0, nBad = 0, logCnt = 0, pulseErr = 0;
  logic [7:0] logAddr [256];
  logic [7:0] logData [256];
  logic prevWr = 1'b0;

  spiCtrlPort i_spiCtrlPort (
    .sysClk(sysClk), .sysRstN(sysRstN), .csN(csN), .cclk(cclk), .cdin(cdin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData), .spiMode(spiMode)
  );

  always #4 sysClk = ~sysClk;

  always @(negedge sysClk) begin
    if (regWrEn && logCnt < 256) begin
      logAddr[logCnt] = regAddr;
      logData[logCnt] = regData;
      logCnt++;
    end
    if (regWrEn && prevWr) pulseErr++;
    prevWr = regWrEn;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge sysClk);
  endtask

  task automatic csDown;
    csN = 1'b0;
    waitClk(5);
  endtask

  task automatic csUp;
    waitClk(5);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      cdin = b[i];
      waitClk(5);
      cclk = 1'b1;
      waitClk(5);
      cclk = 1'b0;
    end
  endtask

  task automatic doReset;
    sysRstN = 1'b0;
    waitClk(3);
    @(negedge sysClk);
    sysRstN = 1'b1;
  endtask

  initial begin
    waitClk(200000);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int base;
    doReset();
    waitClk(2);
    @(negedge sysClk);
    chk(regWrEn == 1'b0, "R1 regWrEn", int'(regWrEn), 0);
    chk(spiMode == 1'b0, "R1 spiMode", int'(spiMode), 0);

    // R10: clock toggling while deselected, before any transaction
    sendBits(8'hFF, 8);
    waitClk(4);
    chk(spiMode == 1'b0, "R2 no cs fall yet", int'(spiMode), 0);

    // R3/R4/R5 sweep of every first-byte value
    for (int h = 0; h < 256; h++) begin
      base = logCnt;
      csDown();
      sendBits(8'(h), 8);
      sendBits(8'(h * 3), 8);
      sendBits(8'(h) ^ 8'hA5, 8);
      csUp();
      if (h == 8'h20) begin
        chk(logCnt == base + 1, "R3 accept count", logCnt - base, 1);
        chk(logAddr[base] == 8'h60, "R3 address", int'(logAddr[base]), 'h60);
        chk(logData[base] == 8'h85, "R3 data", int'(logData[base]), 'h85);
      end else if (h == 8'h21) begin
        chk(logCnt == base, "R5 read bit blocks write", logCnt - base, 0);
      end else begin
        chk(logCnt == base, "R4 wrong device address", logCnt - base, 0);
      end
      if (h == 0) chk(spiMode == 1'b1, "R2 set after cs fall", int'(spiMode), 1);
    end

    // R6: burst across the wrap point
    base = logCnt;
    csDown();
    sendBits(8'h20, 8);
    sendBits(8'hFE, 8);
    for (int k = 0; k < 4; k++) sendBits(8'(8'h3C + k * 17), 8);
    csUp();
    chk(logCnt == base + 4, "R6 burst count", logCnt - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk(logAddr[base + k] == 8'(8'hFE + k), "R6 burst address",
          int'(logAddr[base + k]), int'(8'(8'hFE + k)));
      chk(logData[base + k] == 8'(8'h3C + k * 17), "R6 burst data",
          int'(logData[base + k]), int'(8'(8'h3C + k * 17)));
    end

    // R7: abort mid data byte, then a clean transaction
    base = logCnt;
    csDown();
    sendBits(8'h20, 8);
    sendBits(8'h10, 8);
    sendBits(8'h5A, 8);
    sendBits(8'hFF, 4);
    csUp();
    chk(logCnt == base + 1, "R7 partial byte dropped", logCnt - base, 1);
    base = logCnt;
    csDown();
    sendBits(8'h20, 3);
    csUp();
    csDown();
    sendBits(8'h20, 8);
    sendBits(8'h44, 8);
    sendBits(8'hC3, 8);
    csUp();
    chk(logCnt == base + 1, "R7 restart count", logCnt - base, 1);
    chk(logAddr[base] == 8'h44 && logData[base] == 8'hC3, "R7 restart content",
        int'({logAddr[base], logData[base]}), 'h44C3);

    // R8: stop after address, stop during pointer
    base = logCnt;
    csDown(); sendBits(8'h20, 8); csUp();
    csDown(); sendBits(8'h20, 8); sendBits(8'h77, 5); csUp();
    chk(logCnt == base, "R8 no data byte", logCnt - base, 0);

    // R10: cclk while deselected, then a transaction is aligned
    sendBits(8'hAA, 5);
    base = logCnt;
    csDown(); sendBits(8'h20, 8); sendBits(8'h09, 8); sendBits(8'h81, 8); csUp();
    chk(logCnt == base + 1 && logAddr[base] == 8'h09 && logData[base] == 8'h81,
        "R10 alignment after stray clocks", int'({logAddr[base], logData[base]}), 'h0981);

    chk(pulseErr == 0, "R9 strobe width", pulseErr, 0);

    doReset();
    waitClk(2);
    @(negedge sysClk);
    chk(spiMode == 1'b0, "R2 cleared by reset", int'(spiMode), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule